// File: doc/BRIEF.md
# Pack, Compare and Inverted-Logic Unit

This unit is one execution-stage slice of a 64-bit integer datapath. It takes two source operands, a four-bit operation code and a word-mode flag. From these it produces one result. The result is built by one of four kinds of operation: a logic operation with the second operand inverted, placing operand halves or bytes side by side, picking the smaller or larger operand, or widening a byte or half-word by sign extension.

The operation logic is combinational. The result and an illegal flag are held in one output register, so a result appears on the cycle after its operands. The word-mode flag only affects the two packing operations. With the flag set, they build a 32-bit value and sign-extend it from bit 31. The datapath width is a parameter. With a width of 32 there is no word mode, so a word-mode packing request is flagged as illegal. Decode, operand fetch and trap handling belong to the surrounding pipeline.

Top module: `pkalu_top`

## Requirements
- R1: Code 0 gives in_a AND NOT in_b. Code 1 gives in_a OR NOT in_b. Code 2 gives NOT (in_a XOR in_b).
- R2: Code 3 with in_word low places the low half of in_a in the low half of the result and the low half of in_b in the high half.
- R3: Code 4 with in_word low places the high half of in_a in the low half of the result and the high half of in_b in the high half.
- R4: Code 5 places in_a[7:0] in result[7:0] and in_b[7:0] in result[15:8]. All bits above 15 are zero.
- R5: Code 3 with in_word high (width 64) forms {in_b[15:0], in_a[15:0]} and sign-extends bit 31 of that value to the full width.
- R6: Code 4 with in_word high (width 64) forms {in_b[31:16], in_a[31:16]} and sign-extends bit 31 of that value to the full width.
- R7: Code 6 returns the smaller and code 7 the larger operand, both comparing as two's-complement signed values.
- R8: Code 8 returns the smaller and code 9 the larger operand, both comparing as unsigned values.
- R9: Code 10 sign-extends in_a from bit 7. Code 11 sign-extends in_a from bit 15.
- R10: in_word has no effect on any code other than 3 and 4.
- R11: out_illegal rises, with out_result zero, for codes 12 to 15, and for codes 3 and 4 with in_word high when the width is 32.
- R12: The outputs change on the clock edge after the operands are presented. While rst_n is low, out_result and out_illegal are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_op | input | 4 | Operation code |
| in_word | input | 1 | Word-mode select for the packing codes |
| in_a | input | DW (64) | First operand |
| in_b | input | DW (64) | Second operand |
| out_result | output | DW (64) | Registered result |
| out_illegal | output | 1 | Registered illegal-request flag |

## Verification
The operands are chosen so that every half and byte of in_a and in_b is distinct. A pack result with the wrong lane or wrong source is then visible at once. The compare codes run on pairs where signed and unsigned order disagree, so a swapped signed/unsigned compare shows up; equal operands and the most negative value test the edge of the compare. The sign-extension and word-pack codes run with the sign bit both set and clear. A second instance at width 32 shows that word-mode packing is flagged there, while the narrow pack codes still split the 32-bit operands into 16-bit halves.

// File: rtl/pkalu_pkg.sv
package pkalu_pkg;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ANDN  = 4'd0,
        OP_ORN   = 4'd1,
        OP_XNOR  = 4'd2,
        OP_PACK  = 4'd3,
        OP_PACKU = 4'd4,
        OP_PACKH = 4'd5,
        OP_MIN   = 4'd6,
        OP_MAX   = 4'd7,
        OP_MINU  = 4'd8,
        OP_MAXU  = 4'd9,
        OP_SEXTB = 4'd10,
        OP_SEXTH = 4'd11
    } pk_op_e;
endpackage

// File: rtl/pkalu_logic.sv
module pkalu_logic #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] and_inv,
    output logic [DW-1:0] or_inv,
    output logic [DW-1:0] equiv
);
    logic [DW-1:0] b_n;

    assign b_n     = ~b;
    assign and_inv = a & b_n;
    assign or_inv  = a | b_n;
    assign equiv   = a ^ b_n;
endmodule

// File: rtl/pkalu_pack.sv
module pkalu_pack #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          upper,
    input  logic          word,
    output logic [DW-1:0] half_res,
    output logic [DW-1:0] byte_res,
    output logic          word_bad
);
    localparam int HW = DW / 2;

    logic [DW-1:0] full_res;
    logic [DW-1:0] word_res;

    assign full_res = upper ? {b[DW-1:HW], a[DW-1:HW]} : {b[HW-1:0], a[HW-1:0]};
    assign byte_res = {{(DW-16){1'b0}}, b[7:0], a[7:0]};

    generate
        if (DW >= 64) begin : g_word
            logic [31:0] w32;
            assign w32      = upper ? {b[31:16], a[31:16]} : {b[15:0], a[15:0]};
            assign word_res = {{(DW-32){w32[31]}}, w32};
            assign word_bad = 1'b0;
        end else begin : g_noword
            assign word_res = '0;
            assign word_bad = word;
        end
    endgenerate

    assign half_res = word ? word_res : full_res;
endmodule

// File: rtl/pkalu_cmp.sv
module pkalu_cmp #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          is_signed,
    input  logic          take_max,
    output logic [DW-1:0] pick
);
    logic a_lt_b;

    always_comb begin
        if (is_signed) a_lt_b = $signed(a) < $signed(b);
        else           a_lt_b = a < b;
        if (take_max)  pick = a_lt_b ? b : a;
        else           pick = a_lt_b ? a : b;
    end
endmodule

// File: rtl/pkalu_top.sv
module pkalu_top
    import pkalu_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    in_op,
    input  logic          in_word,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    output logic [DW-1:0] out_result,
    output logic          out_illegal
);
    logic [DW-1:0] and_inv, or_inv, equiv;
    logic [DW-1:0] half_res, byte_res, pick;
    logic          word_bad;
    logic          cmp_signed, cmp_max;
    logic [DW-1:0] nxt_result;
    logic          nxt_illegal;

    assign cmp_signed = (in_op == OP_MIN) || (in_op == OP_MAX);
    assign cmp_max    = (in_op == OP_MAX) || (in_op == OP_MAXU);

    pkalu_logic #(.DW(DW)) u_logic (
        .a(in_a), .b(in_b),
        .and_inv(and_inv), .or_inv(or_inv), .equiv(equiv)
    );

    pkalu_pack #(.DW(DW)) u_pack (
        .a(in_a), .b(in_b),
        .upper(in_op == OP_PACKU), .word(in_word),
        .half_res(half_res), .byte_res(byte_res), .word_bad(word_bad)
    );

    pkalu_cmp #(.DW(DW)) u_cmp (
        .a(in_a), .b(in_b),
        .is_signed(cmp_signed), .take_max(cmp_max),
        .pick(pick)
    );

    always_comb begin
        nxt_result  = '0;
        nxt_illegal = 1'b0;
        case (in_op)
            OP_ANDN:  nxt_result = and_inv;
            OP_ORN:   nxt_result = or_inv;
            OP_XNOR:  nxt_result = equiv;
            OP_PACK,
            OP_PACKU: begin
                nxt_illegal = word_bad;
                nxt_result  = word_bad ? '0 : half_res;
            end
            OP_PACKH: nxt_result = byte_res;
            OP_MIN,
            OP_MAX,
            OP_MINU,
            OP_MAXU:  nxt_result = pick;
            OP_SEXTB: nxt_result = {{(DW-8){in_a[7]}}, in_a[7:0]};
            OP_SEXTH: nxt_result = {{(DW-16){in_a[15]}}, in_a[15:0]};
            default:  nxt_illegal = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_result  <= nxt_result;
            out_illegal <= nxt_illegal;
        end
    end
endmodule

// File: rtl/pkalu_checker.sv
module pkalu_checker #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    in_op,
    input logic [DW-1:0] in_a,
    input logic [DW-1:0] in_b,
    input logic [DW-1:0] out_result,
    input logic          out_illegal
);
    p_andn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_op == 4'd0) |=> out_result == ($past(in_a) & ~$past(in_b)));

    p_packh_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_op == 4'd5) |=> out_result[DW-1:16] == '0);

    p_signed_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_op == 4'd6) |=> !($signed(out_result) > $signed($past(in_a)))
                          && !($signed(out_result) > $signed($past(in_b))));

    p_unsigned_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_op == 4'd9) |=> (out_result >= $past(in_a)) && (out_result >= $past(in_b)));

    p_sextb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_op == 4'd10) |=> out_result == {{(DW-8){$past(in_a[7])}}, $past(in_a[7:0])});

    p_illegal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_result == '0);

    p_bad_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_op >= 4'd12) |=> out_illegal);
endmodule

bind pkalu_top pkalu_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_op(in_op),
    .in_a(in_a), .in_b(in_b),
    .out_result(out_result), .out_illegal(out_illegal)
);

// File: tb/pkalu_top_test.sv
module pkalu_top_test;
    typedef struct {
        logic [63:0] r64;
        logic        i64;
        logic [63:0] r32;
        logic        i32;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  in_op = 4'd0;
    logic        in_word = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic [63:0] out_result;
    logic        out_illegal;
    logic [31:0] out32;
    logic        ill32;

    item_t sb[$];
    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pkalu_top #(.DW(64)) uut (
        .clk(clk), .rst_n(rst_n), .in_op(in_op), .in_word(in_word),
        .in_a(in_a), .in_b(in_b), .out_result(out_result), .out_illegal(out_illegal)
    );

    pkalu_top #(.DW(32)) uut32 (
        .clk(clk), .rst_n(rst_n), .in_op(in_op), .in_word(in_word),
        .in_a(in_a[31:0]), .in_b(in_b[31:0]), .out_result(out32), .out_illegal(ill32)
    );

    function automatic void model(input logic [3:0] op, input logic word,
                                  input logic [63:0] a, input logic [63:0] b,
                                  input int w, output logic [63:0] r, output logic ill);
        logic [63:0] m;
        logic lt;
        m = (w == 64) ? '1 : 64'h0000_0000_ffff_ffff;
        r = '0;
        ill = 1'b0;
        case (op)
            4'd0: r = a & ~b & m;
            4'd1: r = (a | ~b) & m;
            4'd2: r = ~(a ^ b) & m;
            4'd3: if (word) begin
                      if (w == 32) ill = 1'b1;
                      else r = {{32{b[15]}}, b[15:0], a[15:0]};
                  end else
                      r = (w == 64) ? {b[31:0], a[31:0]} : {32'b0, b[15:0], a[15:0]};
            4'd4: if (word) begin
                      if (w == 32) ill = 1'b1;
                      else r = {{32{b[31]}}, b[31:16], a[31:16]};
                  end else
                      r = (w == 64) ? {b[63:32], a[63:32]} : {32'b0, b[31:16], a[31:16]};
            4'd5: r = {48'b0, b[7:0], a[7:0]};
            4'd6, 4'd7: begin
                lt = (w == 64) ? ($signed(a) < $signed(b)) : ($signed(a[31:0]) < $signed(b[31:0]));
                r = ((op == 4'd7) ? (lt ? b : a) : (lt ? a : b)) & m;
            end
            4'd8, 4'd9: begin
                lt = (a & m) < (b & m);
                r = ((op == 4'd9) ? (lt ? b : a) : (lt ? a : b)) & m;
            end
            4'd10: r = {{56{a[7]}}, a[7:0]} & m;
            4'd11: r = {{48{a[15]}}, a[15:0]} & m;
            default: ill = 1'b1;
        endcase
    endfunction

    task automatic drive(input logic [3:0] op, input logic word,
                         input logic [63:0] a, input logic [63:0] b, input string tag);
        item_t it;
        @(negedge clk);
        in_op = op; in_word = word; in_a = a; in_b = b;
        model(op, word, a, b, 64, it.r64, it.i64);
        model(op, word, a, b, 32, it.r32, it.i32);
        it.tag = tag;
        sb.push_back(it);
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            vectors++;
            if (out_result !== it.r64 || out_illegal !== it.i64) begin
                miscompares++;
                $display("FAIL %s w64: result=%h ill=%b expected result=%h ill=%b",
                         it.tag, out_result, out_illegal, it.r64, it.i64);
            end
            vectors++;
            if (out32 !== it.r32[31:0] || ill32 !== it.i32) begin
                miscompares++;
                $display("FAIL %s w32: result=%h ill=%b expected result=%h ill=%b",
                         it.tag, out32, ill32, it.r32[31:0], it.i32);
            end
        end
    end

    localparam logic [63:0] VA = 64'h8123_4567_89ab_cdef;
    localparam logic [63:0] VB = 64'h7edc_ba98_7654_3210;

    initial begin
        in_op = 4'd2; in_a = VA; in_b = VB;
        repeat (3) @(negedge clk);
        vectors++;
        if (out_result !== '0 || out_illegal !== 1'b0 || out32 !== '0 || ill32 !== 1'b0) begin
            miscompares++;
            $display("FAIL R12 reset: result=%h ill=%b expected result=0 ill=0", out_result, out_illegal);
        end
        rst_n = 1'b1;

        drive(4'd0, 0, VA, VB, "R1 andn");
        drive(4'd1, 0, VA, VB, "R1 orn");
        drive(4'd2, 0, VA, VB, "R1 xnor");
        drive(4'd0, 0, '1, 64'h00ff_00ff_0f0f_f0f0, "R1 andn mask");
        drive(4'd3, 0, VA, VB, "R2 pack");
        drive(4'd3, 0, VB, VA, "R2 pack swapped");
        drive(4'd4, 0, VA, VB, "R3 packu");
        drive(4'd4, 0, VB, VA, "R3 packu swapped");
        drive(4'd5, 0, VA, VB, "R4 packh");
        drive(4'd5, 0, '1, '1, "R4 packh ones");
        drive(4'd3, 1, VA, VB, "R5 packw positive");
        drive(4'd3, 1, VB, VA, "R5 packw negative");
        drive(4'd4, 1, VA, VB, "R6 packuw positive");
        drive(4'd4, 1, VB, VA, "R6 packuw negative");
        drive(4'd6, 0, VA, VB, "R7 min signed");
        drive(4'd7, 0, VA, VB, "R7 max signed");
        drive(4'd6, 0, 64'h8000_0000_0000_0000, 64'h7fff_ffff_ffff_ffff, "R7 min extreme");
        drive(4'd7, 0, 64'd5, 64'd5, "R7 max equal");
        drive(4'd6, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_7fff_ffff, "R7 min low word sign");
        drive(4'd8, 0, VA, VB, "R8 minu");
        drive(4'd9, 0, VA, VB, "R8 maxu");
        drive(4'd8, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_7fff_ffff, "R8 minu low word");
        drive(4'd9, 0, '1, 64'd1, "R8 maxu all ones");
        drive(4'd10, 0, VA, VB, "R9 sextb negative");
        drive(4'd10, 0, 64'hffff_ffff_ffff_ff7f, VB, "R9 sextb positive");
        drive(4'd11, 0, VA, VB, "R9 sexth negative");
        drive(4'd11, 0, 64'hffff_ffff_ffff_7fff, VB, "R9 sexth positive");
        drive(4'd0, 1, VA, VB, "R10 andn word");
        drive(4'd5, 1, VA, VB, "R10 packh word");
        drive(4'd7, 1, VA, VB, "R10 max word");
        drive(4'd11, 1, VA, VB, "R10 sexth word");
        drive(4'd12, 0, VA, VB, "R11 code 12");
        drive(4'd15, 1, VA, VB, "R11 code 15");
        drive(4'd1, 0, VA, VB, "R12 recovery after illegal");
        repeat (3) @(negedge clk);
        vectors++;
        if (sb.size() != 0) begin
            miscompares++;
            $display("FAIL R12 pending: %0d items left expected 0", sb.size());
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL R12 watchdog: run did not end, expected end");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule